// File: doc/BRIEF.md
# Digital IF Channel Downconverter

This block takes a quadrature IF sample stream in which two aggregated channels sit on opposite sides of zero frequency, and moves one of them to baseband. An internal numerically controlled oscillator produces cosine and sine samples from a stored quarter-wave table. The block multiplies the I and Q words by those samples, sums the products into baseband in-phase and quadrature words, and then smooths both with a fixed low-pass filter.

The frequency word sets the NCO to the IF offset of the wanted channel, so that channel lands at DC. A per-sample select input picks the channel on the positive or on the negative side of the complex spectrum. Samples are accepted one per clock whenever the input valid is high. Each extra aggregated channel is served by another instance fed from the same stream.

Top module: `ddc_channel`

## Requirements
- R1: While reset is held and after it is released, until an output is produced, out_valid is 0 and out_i and out_q are 0.
- R2: A 24-bit phase accumulator clears to 0 on reset. Each accepted sample uses the accumulator value held before that sample, and then adds the freq_word present with that sample, modulo 2^24. A new freq_word therefore affects the phase from the following sample on, with no phase jump.
- R3: The table address a is phase bits [23:14]. Let T[k] = floor(8191*sin((2k+1)*pi/1024) + 0.5) for k = 0..255, with quadrant a[9:8] and index m = a[7:0]. Quadrant 0 gives sin = T[m] and cos = T[255-m]. Quadrant 1 gives sin = T[255-m] and cos = -T[m]. Quadrant 2 gives sin = -T[m] and cos = -T[255-m]. Quadrant 3 gives sin = -T[255-m] and cos = T[m].
- R4: chan_sel = 0 selects the positive-frequency channel, with bi = I*cos + Q*sin and bq = Q*cos - I*sin. chan_sel = 1 selects the negative-frequency channel, with bi = I*cos - Q*sin and bq = Q*cos + I*sin. All products are at full precision.
- R5: Each mixer sum is rounded as floor((sum + 4096) / 8192) and then saturated to the 14-bit signed range [-8192, 8191]. It never wraps.
- R6: The filter is 16 taps long, y = sum over k of h[k]*b[n-k], where b[n] is the newest mixer output. The coefficients h[0..7] are -3, -6, 0, 22, 64, 112, 150, 173, and h[15-k] = h[k] (DC gain 1024). The output is floor((y + 512) / 1024), saturated to [-8192, 8191].
- R7: No output is produced before 16 samples have been accepted after reset. The 16th accepted sample gives the first output.
- R8: The output for a sample accepted at clock edge n is valid after edge n+5. From the 16th accepted sample onwards, every accepted sample gives exactly one output, in order, with both lanes valid together.
- R9: While in_valid is 0, the data, frequency word and select inputs are ignored: the phase does not advance, the filter does not shift and no output is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Qualifies the input sample in this cycle |
| in_i | input | 14 | IF in-phase sample, signed |
| in_q | input | 14 | IF quadrature sample, signed |
| freq_word | input | 24 | NCO phase increment per accepted sample |
| chan_sel | input | 1 | 0 = positive-frequency channel, 1 = negative-frequency channel |
| out_valid | output | 1 | Baseband sample valid |
| out_i | output | 14 | Baseband in-phase output, signed |
| out_q | output | 14 | Baseband quadrature output, signed |

## Verification
A wrong phase accumulator shows up as a mismatch on both output lanes five cycles after the first sample whose phase is wrong, and it stays visible for every sample after that, because the phase error is never undone. A bad table entry or a wrong quadrant sign corrupts only the samples whose phase lands on that entry or quadrant, so the stimulus sweeps many frequency words, including ones near the wrap point. A fill counter that is off shows as out_valid rising one sample early or late. A sign error in the channel-select path flips the quadrature lane at once. Saturation faults appear only with full-scale inputs, which directed cases supply at the mixer and at the filter.

// File: rtl/ddc_pkg.sv
package ddc_pkg;

   // fixed low-pass filter geometry
   localparam int FIR_TAPS  = 16;
   localparam int FIR_HALF  = FIR_TAPS / 2;
   localparam int COEF_W    = 10;
   localparam int FIR_SHIFT = 10;

   // symmetric coefficient set, unity DC gain after FIR_SHIFT
   function automatic logic signed [COEF_W-1:0] fir_coef(input int k);
      int m;
      int v;
      m = (k < FIR_HALF) ? k : FIR_TAPS - 1 - k;
      case (m)
         0:       v = -3;
         1:       v = -6;
         2:       v = 0;
         3:       v = 22;
         4:       v = 64;
         5:       v = 112;
         6:       v = 150;
         default: v = 173;
      endcase
      return COEF_W'(v);
   endfunction

endpackage

// File: rtl/ddc_nco.sv
module ddc_nco #(
   parameter int PHASE_W = 24,
   parameter int LUT_AW  = 10,
   parameter int AMP_W   = 14
)(
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    adv,
   input  logic [PHASE_W-1:0]      fcw,
   output logic signed [AMP_W-1:0] sin_o,
   output logic signed [AMP_W-1:0] cos_o
);
   localparam int  QW     = LUT_AW - 2;
   localparam int  QN     = 1 << QW;
   localparam real AMP_R  = (2.0 ** (AMP_W - 1)) - 1.0;
   localparam real PI_R   = 3.14159265358979323846;
   localparam longint AMP_I = (longint'(1) << (AMP_W - 1)) - 1;
   localparam longint AMP_SQ = AMP_I * AMP_I;
   localparam longint MAG_TOL = 2 * AMP_I + 2;

   logic [PHASE_W-1:0]      acc;
   logic [LUT_AW-1:0]       ph_r;
   logic signed [AMP_W-1:0] qtab [QN];

   // quarter-wave table, sampled at half-step offsets for exact mirroring
   for (genvar k = 0; k < QN; k++) begin : g_tab
      localparam real ANG = (2.0 * k + 1.0) * PI_R / (4.0 * QN);
      localparam int  VAL = $rtoi($floor(AMP_R * $sin(ANG) + 0.5));
      assign qtab[k] = AMP_W'(VAL);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc  <= '0;
         ph_r <= '0;
      end else if (adv) begin
         ph_r <= acc[PHASE_W-1 -: LUT_AW];
         acc  <= acc + fcw;
      end
   end

   logic [1:0]              quad;
   logic [QW-1:0]           idx;
   logic signed [AMP_W-1:0] fwd, rev, sin_c, cos_c;

   always_comb begin
      quad = ph_r[LUT_AW-1 -: 2];
      idx  = ph_r[QW-1:0];
      fwd  = qtab[idx];
      rev  = qtab[~idx];
      case (quad)
         2'd0:    begin sin_c = fwd;  cos_c = rev;  end
         2'd1:    begin sin_c = rev;  cos_c = -fwd; end
         2'd2:    begin sin_c = -fwd; cos_c = -rev; end
         default: begin sin_c = -rev; cos_c = fwd;  end
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sin_o <= '0;
         cos_o <= '0;
      end else begin
         sin_o <= sin_c;
         cos_o <= cos_c;
      end
   end

   // R3: quadrant signs of the registered sinusoids follow the phase
   assert_quad0_sign_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (quad == 2'd0) |=> (sin_o >= 0 && cos_o >= 0));
   assert_quad2_sign_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (quad == 2'd2) |=> (sin_o <= 0 && cos_o <= 0));
   // R3: cosine and sine stay on the unit circle within rounding
   assert_unit_mag_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> ((longint'(sin_o) * sin_o + longint'(cos_o) * cos_o - AMP_SQ) <= MAG_TOL &&
                 (AMP_SQ - longint'(sin_o) * sin_o - longint'(cos_o) * cos_o) <= MAG_TOL));
   // R9: the phase holds while no sample is accepted
   assert_phase_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !adv |=> $stable(acc));

endmodule

// File: rtl/ddc_mixer.sv
module ddc_mixer #(
   parameter int DATA_W = 14,
   parameter int AMP_W  = 14
)(
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     v_i,
   input  logic                     sel_i,
   input  logic signed [DATA_W-1:0] i_i,
   input  logic signed [DATA_W-1:0] q_i,
   input  logic signed [AMP_W-1:0]  sin_i,
   input  logic signed [AMP_W-1:0]  cos_i,
   output logic                     v_o,
   output logic signed [DATA_W-1:0] bi_o,
   output logic signed [DATA_W-1:0] bq_o
);
   localparam int SW   = DATA_W + AMP_W + 1;
   localparam int RS   = AMP_W - 1;
   localparam int MAXV = (1 << (DATA_W - 1)) - 1;
   localparam logic signed [SW-1:0] HI   = SW'(MAXV);
   localparam logic signed [SW-1:0] LO   = SW'(-MAXV - 1);
   localparam logic signed [SW-1:0] HALF = SW'(longint'(1) << (RS - 1));

   function automatic logic signed [DATA_W-1:0] rnd_sat(input logic signed [SW-1:0] x);
      logic signed [SW-1:0] y;
      y = (x + HALF) >>> RS;
      if (y > HI)      return HI[DATA_W-1:0];
      else if (y < LO) return LO[DATA_W-1:0];
      else             return y[DATA_W-1:0];
   endfunction

   logic signed [SW-1:0] ic, qs, qc, is_p, sum_i, sum_q;

   always_comb begin
      ic   = SW'(i_i) * SW'(cos_i);
      qs   = SW'(q_i) * SW'(sin_i);
      qc   = SW'(q_i) * SW'(cos_i);
      is_p = SW'(i_i) * SW'(sin_i);
      if (sel_i) begin
         sum_i = ic - qs;
         sum_q = qc + is_p;
      end else begin
         sum_i = ic + qs;
         sum_q = qc - is_p;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         v_o  <= 1'b0;
         bi_o <= '0;
         bq_o <= '0;
      end else begin
         v_o  <= v_i;
         bi_o <= rnd_sat(sum_i);
         bq_o <= rnd_sat(sum_q);
      end
   end

   // R4: a silent input yields a silent product regardless of the oscillator
   assert_zero_in_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (v_i && i_i == 0 && q_i == 0) |=> (bi_o == 0 && bq_o == 0));

endmodule

// File: rtl/ddc_fir.sv
module ddc_fir #(
   parameter int DATA_W = 14
)(
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     v_i,
   input  logic signed [DATA_W-1:0] x_i,
   output logic                     v_o,
   output logic signed [DATA_W-1:0] y_o
);
   import ddc_pkg::*;

   localparam int CNT_W = $clog2(FIR_TAPS + 1);
   localparam int PSW   = DATA_W + 1;
   localparam int PRW   = PSW + COEF_W;
   localparam int AW    = PRW + $clog2(FIR_HALF) + 1;
   localparam int MAXV  = (1 << (DATA_W - 1)) - 1;
   localparam logic signed [AW-1:0] HI   = AW'(MAXV);
   localparam logic signed [AW-1:0] LO   = AW'(-MAXV - 1);
   localparam logic signed [AW-1:0] HALF = AW'(longint'(1) << (FIR_SHIFT - 1));

   logic signed [DATA_W-1:0] tap [FIR_TAPS];
   logic [CNT_W-1:0]         fill;
   logic                     tv, pv;
   logic signed [PRW-1:0]    prod_r [FIR_HALF];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fill <= '0;
         tv   <= 1'b0;
         for (int k = 0; k < FIR_TAPS; k++) tap[k] <= '0;
      end else begin
         tv <= v_i && (fill >= CNT_W'(FIR_TAPS - 1));
         if (v_i) begin
            tap[0] <= x_i;
            for (int k = 1; k < FIR_TAPS; k++) tap[k] <= tap[k-1];
            if (fill != CNT_W'(FIR_TAPS)) fill <= fill + 1'b1;
         end
      end
   end

   // pre-add mirrored taps, one multiplier per coefficient pair
   for (genvar h = 0; h < FIR_HALF; h++) begin : g_pair
      logic signed [PSW-1:0] ps;
      assign ps = PSW'(tap[h]) + PSW'(tap[FIR_TAPS-1-h]);
      always_ff @(posedge clk) begin
         if (!rst_n) prod_r[h] <= '0;
         else        prod_r[h] <= PRW'(ps) * PRW'(fir_coef(h));
      end
   end

   logic signed [AW-1:0] sum_c, rnd_c;

   always_comb begin
      sum_c = '0;
      for (int h = 0; h < FIR_HALF; h++) sum_c = sum_c + AW'(prod_r[h]);
      rnd_c = (sum_c + HALF) >>> FIR_SHIFT;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pv  <= 1'b0;
         v_o <= 1'b0;
         y_o <= '0;
      end else begin
         pv  <= tv;
         v_o <= pv;
         if (pv) begin
            if (rnd_c > HI)      y_o <= HI[DATA_W-1:0];
            else if (rnd_c < LO) y_o <= LO[DATA_W-1:0];
            else                 y_o <= rnd_c[DATA_W-1:0];
         end
      end
   end

endmodule

// File: rtl/ddc_channel.sv
module ddc_channel #(
   parameter int DATA_W  = 14,
   parameter int PHASE_W = 24,
   parameter int LUT_AW  = 10,
   parameter int AMP_W   = 14
)(
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     in_valid,
   input  logic signed [DATA_W-1:0] in_i,
   input  logic signed [DATA_W-1:0] in_q,
   input  logic [PHASE_W-1:0]       freq_word,
   input  logic                     chan_sel,
   output logic                     out_valid,
   output logic signed [DATA_W-1:0] out_i,
   output logic signed [DATA_W-1:0] out_q
);
   import ddc_pkg::*;

   localparam int SEEN_W = $clog2(FIR_TAPS + 1);

   if (DATA_W < 4 || DATA_W > 24) begin : g_chk_data
      $error("ddc_channel: DATA_W out of range");
   end
   if (LUT_AW < 4 || LUT_AW > PHASE_W) begin : g_chk_lut
      $error("ddc_channel: LUT_AW must lie within PHASE_W");
   end
   if (AMP_W < 4 || AMP_W > 20) begin : g_chk_amp
      $error("ddc_channel: AMP_W out of range");
   end
   if ((FIR_TAPS % 2) != 0) begin : g_chk_taps
      $error("ddc_channel: filter must have an even tap count");
   end

   // stage 1: capture the accepted sample
   logic                     s1_v, s1_sel;
   logic signed [DATA_W-1:0] s1_i, s1_q;
   // stage 2: aligned with the oscillator lookup
   logic                     s2_v, s2_sel;
   logic signed [DATA_W-1:0] s2_i, s2_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s1_v <= 1'b0; s1_sel <= 1'b0; s1_i <= '0; s1_q <= '0;
         s2_v <= 1'b0; s2_sel <= 1'b0; s2_i <= '0; s2_q <= '0;
      end else begin
         s1_v <= in_valid;
         if (in_valid) begin
            s1_sel <= chan_sel;
            s1_i   <= in_i;
            s1_q   <= in_q;
         end
         s2_v   <= s1_v;
         s2_sel <= s1_sel;
         s2_i   <= s1_i;
         s2_q   <= s1_q;
      end
   end

   logic signed [AMP_W-1:0]  nco_sin, nco_cos;
   logic                     mix_v;
   logic signed [DATA_W-1:0] mix_i, mix_q;
   logic                     fir_q_v;

   ddc_nco #(.PHASE_W(PHASE_W), .LUT_AW(LUT_AW), .AMP_W(AMP_W)) u_nco (
      .clk(clk), .rst_n(rst_n), .adv(in_valid), .fcw(freq_word),
      .sin_o(nco_sin), .cos_o(nco_cos));

   ddc_mixer #(.DATA_W(DATA_W), .AMP_W(AMP_W)) u_mix (
      .clk(clk), .rst_n(rst_n), .v_i(s2_v), .sel_i(s2_sel),
      .i_i(s2_i), .q_i(s2_q), .sin_i(nco_sin), .cos_i(nco_cos),
      .v_o(mix_v), .bi_o(mix_i), .bq_o(mix_q));

   ddc_fir #(.DATA_W(DATA_W)) u_fir_i (
      .clk(clk), .rst_n(rst_n), .v_i(mix_v), .x_i(mix_i),
      .v_o(out_valid), .y_o(out_i));

   ddc_fir #(.DATA_W(DATA_W)) u_fir_q (
      .clk(clk), .rst_n(rst_n), .v_i(mix_v), .x_i(mix_q),
      .v_o(fir_q_v), .y_o(out_q));

   // count of accepted samples, kept only for the checks below
   logic [SEEN_W-1:0] chk_seen;
   always_ff @(posedge clk) begin
      if (!rst_n)                                         chk_seen <= '0;
      else if (in_valid && chk_seen != SEEN_W'(FIR_TAPS)) chk_seen <= chk_seen + 1'b1;
   end

   assert_fill_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (chk_seen == SEEN_W'(FIR_TAPS)));
   assert_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(in_valid, 6));
   assert_lanes_aligned_R8: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == fir_q_v);
   assert_reset_quiet_R1: assert property (@(posedge clk)
      !rst_n |=> (!out_valid && out_i == 0 && out_q == 0));

endmodule

// File: tb/ddc_channel_tb_top.sv
`timescale 1ns/1ps
module ddc_channel_tb_top;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              in_valid = 1'b0;
   logic signed [13:0] in_i = '0;
   logic signed [13:0] in_q = '0;
   logic [23:0]       freq_word = '0;
   logic              chan_sel = 1'b0;
   logic              out_valid;
   logic signed [13:0] out_i, out_q;

   always #2 clk = ~clk;

   ddc_channel dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
      .freq_word(freq_word), .chan_sel(chan_sel),
      .out_valid(out_valid), .out_i(out_i), .out_q(out_q));

   int     n_chk = 0;
   int     n_err = 0;
   longint cyc = 0;
   bit     mon_on = 1'b0;
   bit     finished = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   // ---------------- reference model from the requirements ----------------
   int     eq_i[$];
   int     eq_q[$];
   longint ec[$];
   longint m_ph;
   int     h_i[16];
   int     h_q[16];
   int     m_fill;

   function automatic int qt(input int k);
      return $rtoi($floor(8191.0 * $sin((2.0 * k + 1.0) * 3.14159265358979323846 / 1024.0) + 0.5));
   endfunction

   function automatic int bcoef(input int k);
      int m;
      int c[8] = '{-3, -6, 0, 22, 64, 112, 150, 173};
      m = (k < 8) ? k : 15 - k;
      return c[m];
   endfunction

   function automatic int sat14(input longint x);
      if (x > 8191) return 8191;
      if (x < -8192) return -8192;
      return int'(x);
   endfunction

   function automatic int rnd14();
      logic [13:0] r;
      r = 14'($urandom);
      return int'($signed(r));
   endfunction

   task automatic model_reset();
      m_ph = 0;
      m_fill = 0;
      for (int k = 0; k < 16; k++) begin h_i[k] = 0; h_q[k] = 0; end
      eq_i.delete(); eq_q.delete(); ec.delete();
   endtask

   task automatic send(input bit v, input int i, input int q, input int f, input bit s);
      int a, quad, idx, sn, cs, bi, bq;
      longint pi_, pq_, yi, yq;
      @(negedge clk);
      in_valid  = v;
      in_i      = 14'(i);
      in_q      = 14'(q);
      freq_word = 24'(f);
      chan_sel  = s;
      if (v) begin
         a = int'(m_ph >> 14);
         quad = a >> 8;
         idx = a & 255;
         case (quad)
            0: begin sn = qt(idx);        cs = qt(255 - idx);  end
            1: begin sn = qt(255 - idx);  cs = -qt(idx);       end
            2: begin sn = -qt(idx);       cs = -qt(255 - idx); end
            default: begin sn = -qt(255 - idx); cs = qt(idx);  end
         endcase
         m_ph = (m_ph + longint'(f)) & 64'hFF_FFFF;
         if (!s) begin
            pi_ = longint'(i) * cs + longint'(q) * sn;
            pq_ = longint'(q) * cs - longint'(i) * sn;
         end else begin
            pi_ = longint'(i) * cs - longint'(q) * sn;
            pq_ = longint'(q) * cs + longint'(i) * sn;
         end
         bi = sat14((pi_ + 4096) >>> 13);
         bq = sat14((pq_ + 4096) >>> 13);
         for (int k = 15; k > 0; k--) begin h_i[k] = h_i[k-1]; h_q[k] = h_q[k-1]; end
         h_i[0] = bi;
         h_q[0] = bq;
         if (m_fill < 16) m_fill++;
         if (m_fill == 16) begin
            yi = 0; yq = 0;
            for (int k = 0; k < 16; k++) begin
               yi += longint'(bcoef(k)) * h_i[k];
               yq += longint'(bcoef(k)) * h_q[k];
            end
            eq_i.push_back(sat14((yi + 512) >>> 10));
            eq_q.push_back(sat14((yq + 512) >>> 10));
            ec.push_back(cyc + 6);
         end
      end
   endtask

   // ---------------- output monitor ----------------
   always @(negedge clk) begin
      if (mon_on) begin
         if (out_valid) begin
            n_chk++;
            if (ec.size() == 0) begin
               n_err++;
               $display("FAIL R7,R9 unexpected out_valid: got 1 exp 0 at cycle %0d", cyc);
            end else begin
               if (cyc != ec[0]) begin
                  n_err++;
                  $display("FAIL R8 output cycle: got %0d exp %0d", cyc, ec[0]);
               end
               n_chk++;
               if (out_i !== 14'(eq_i[0])) begin
                  n_err++;
                  $display("FAIL R2,R3,R4,R5,R6 out_i: got %0d exp %0d", out_i, eq_i[0]);
               end
               n_chk++;
               if (out_q !== 14'(eq_q[0])) begin
                  n_err++;
                  $display("FAIL R2,R3,R4,R5,R6 out_q: got %0d exp %0d", out_q, eq_q[0]);
               end
               void'(eq_i.pop_front()); void'(eq_q.pop_front()); void'(ec.pop_front());
            end
         end else if (ec.size() != 0 && ec[0] <= cyc) begin
            n_chk++; n_err++;
            $display("FAIL R8 missing output: got out_valid 0 exp 1 at cycle %0d", cyc);
            void'(eq_i.pop_front()); void'(eq_q.pop_front()); void'(ec.pop_front());
         end
      end
   end

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
   endtask

   // ---------------- watchdog ----------------
   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_err++;
         $display("FAIL watchdog: got timeout exp completion");
         summary();
         $finish;
      end
   end

   // ---------------- stimulus ----------------
   initial begin
      int seen_before;
      void'($urandom(32'd7321));
      model_reset();
      repeat (4) @(negedge clk);
      // R1: outputs quiet under reset
      n_chk++;
      if (out_valid !== 1'b0 || out_i !== 14'sd0 || out_q !== 14'sd0) begin
         n_err++;
         $display("FAIL R1 reset outputs: got v=%0b i=%0d q=%0d exp 0 0 0", out_valid, out_i, out_q);
      end
      @(negedge clk);
      rst_n = 1'b1;
      mon_on = 1'b1;
      @(negedge clk);
      n_chk++;
      if (out_valid !== 1'b0 || out_i !== 14'sd0 || out_q !== 14'sd0) begin
         n_err++;
         $display("FAIL R1 after release: got v=%0b i=%0d q=%0d exp 0 0 0", out_valid, out_i, out_q);
      end

      // R5 R7: full-scale constant at zero frequency saturates the mixer
      for (int n = 0; n < 20; n++) send(1'b1, 8191, 8191, 0, 1'b0);
      // R9: junk while invalid, then check nothing moved
      for (int n = 0; n < 12; n++) send(1'b0, rnd14(), rnd14(), int'($urandom & 24'hFFFFFF), 1'($urandom));
      // R4: negative channel with negative full scale
      for (int n = 0; n < 20; n++) send(1'b1, -8192, -8192, 0, 1'b1);
      // R6: pattern that drives the filter sum beyond range
      for (int r = 0; r < 3; r++)
         for (int k = 15; k >= 0; k--)
            send(1'b1, (bcoef(k) < 0) ? -8192 : 8191, 0, 0, 1'b0);
      // R2: frequency steps and wrap near the top of the phase range
      for (int n = 0; n < 40; n++) send(1'b1, rnd14(), rnd14(), 24'hFFFFF0 + (n % 16), 1'b0);
      for (int n = 0; n < 40; n++) send(1'b1, rnd14(), rnd14(), (n < 20) ? 24'h040000 : 24'h1FFFFF, 1'b1);
      // R3: sweep every table address with a fine step
      for (int n = 0; n < 1100; n++) send(1'b1, 6000, -3000, 24'h004000, n[8]);
      // random mix with gaps
      for (int n = 0; n < 3000; n++) begin
         static int f = 0;
         if ((n % 300) == 0) f = int'($urandom & 24'hFFFFFF);
         send(($urandom % 4) != 0, rnd14(), rnd14(), f, ((n / 500) % 2) == 1);
      end

      // R7: after a reset the first output needs 16 fresh samples
      @(negedge clk);
      in_valid = 1'b0;
      repeat (8) @(negedge clk);
      rst_n = 1'b0;
      mon_on = 1'b0;
      repeat (3) @(negedge clk);
      model_reset();
      rst_n = 1'b1;
      mon_on = 1'b1;
      for (int n = 0; n < 15; n++) send(1'b1, 4000, 1000, 24'h123456, 1'b0);
      send(1'b0, 0, 0, 0, 1'b0);
      seen_before = n_chk;
      repeat (10) @(negedge clk);
      n_chk++;
      if (n_chk - 1 != seen_before) begin
         n_err++;
         $display("FAIL R7 output before 16 samples: got %0d exp 0", n_chk - 1 - seen_before);
      end
      send(1'b1, 4000, 1000, 24'h123456, 1'b0);
      for (int n = 0; n < 10; n++) send(1'b1, rnd14(), rnd14(), 24'h0ABCDE, 1'b1);
      send(1'b0, 0, 0, 0, 1'b0);

      repeat (12) @(negedge clk);
      n_chk++;
      if (ec.size() != 0) begin
         n_err++;
         $display("FAIL R8 outputs left undelivered: got %0d exp 0", ec.size());
      end
      finished = 1'b1;
      summary();
      $finish;
   end

endmodule